// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block takes one 16-bit instruction word with the processor's four condition flags. It works out whether the word is a conditional branch, a counted loop, or neither. For a branch it evaluates the condition that the word selects and, when the branch is taken, adds twice the signed 8-bit displacement to the program counter. The program counter arrives already advanced past the instruction. For the loop form it decrements the selected loop register, returns the new value with a write enable, and jumps backward by twice a 6-bit unsigned distance while the new value is non-zero. The block never alters the flags. The surrounding pipeline owns flag storage and the register file.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through one register stage. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. The result appears on the next edge. While `out_valid` is high and `out_ready` is low, every output holds its value and no new request is taken.

Top module: `brc_unit`

## Requirements
- R1: A word is a branch when bits 14:11 are zero and {bit 15, bits 10:8} is non-zero. It is a loop when bits 15:9 equal 0111111. Any other word gives `out_not_branch`=1, `out_taken`=0, `out_loop_we`=0 and `out_next_pc` equal to the input PC.
- R2: A taken branch gives `out_next_pc` = PC + 2 × sign-extended bits 7:0, modulo 2^16. This reaches from -128 to +127 words.
- R3: With `in_flags` = {N,Z,V,C} (bit 3 is N) and bit 15 = 0, bits 10:8 select the condition: 1 always; 2 Z=0; 3 Z=1; 4 N^V=0; 5 N^V=1; 6 Z|(N^V)=0; 7 Z|(N^V)=1.
- R4: With bit 15 = 1, bits 10:8 select the condition: 0 N=0; 1 N=1; 2 C|Z=0; 3 C|Z=1; 4 V=0; 5 V=1; 6 C=0; 7 C=1.
- R5: A branch whose condition is false gives `out_taken`=0 and `out_next_pc` equal to the input PC, with no loop write.
- R6: For a loop word, `out_loop_idx` = bits 8:6, `out_loop_we`=1 and `out_loop_val` = `in_loop_val` − 1 (modulo 2^16), whether or not the jump is taken. `out_taken` is 1 exactly when that value is non-zero. A taken loop gives `out_next_pc` = PC − 2 × bits 5:0.
- R7: `in_ready` = !`out_valid` | `out_ready`. A request accepted at one edge is presented at the next edge. Outputs are stable while stalled.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_instr | input | 16 | Instruction word |
| in_flags | input | 4 | {N,Z,V,C} |
| in_pc | input | 16 | PC already past the instruction |
| in_loop_val | input | 16 | Current value of the addressed loop register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed |
| out_taken | output | 1 | Control transfer taken |
| out_next_pc | output | 16 | Next program counter |
| out_not_branch | output | 1 | Word is neither branch nor loop |
| out_loop_we | output | 1 | Loop register write enable |
| out_loop_idx | output | 3 | Loop register index |
| out_loop_val | output | 16 | Decremented loop register value |

## Verification
The assertions assume that `in_valid`, once raised, is not withdrawn before acceptance. They also assume that the inputs stay steady during the cycle they are sampled. The stall check assumes that `out_ready` is driven only between edges. The bench drives every request at a falling edge and keeps it in place until `in_ready` has been seen high. It toggles `out_ready` from a random pattern at falling edges only, so that stalls, back-to-back transfers and empty cycles all occur within these assumptions.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_BRANCH = 2'd1,
    K_LOOP   = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [3:0] cond;   // {bit15, bits10:8}
    logic [7:0] disp;   // branch displacement or loop distance in 5:0
    logic [2:0] ridx;   // loop register index
  } dec_t;

  // flag positions inside the {N,Z,V,C} vector
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;
endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [15:0] instr,
  output dec_t        dec
);
  localparam logic [6:0] LOOP_PREFIX = 7'b0111111;

  logic is_branch;
  logic is_loop;

  always_comb begin
    is_loop   = (instr[15:9] == LOOP_PREFIX);
    is_branch = (instr[14:11] == 4'd0) && ({instr[15], instr[10:8]} != 4'd0);
  end

  always_comb begin
    dec.cond = {instr[15], instr[10:8]};
    dec.disp = instr[7:0];
    dec.ridx = instr[8:6];
    if (is_loop)        dec.kind = K_LOOP;
    else if (is_branch) dec.kind = K_BRANCH;
    else                dec.kind = K_NONE;
  end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [3:0] flags,
  input  logic [3:0] cond,
  output logic       cond_ok
);
  localparam int NCOND = 16;

  logic n_f, z_f, v_f, c_f;
  logic [NCOND-1:0] cond_tbl;

  always_comb begin
    n_f = flags[FLAG_N];
    z_f = flags[FLAG_Z];
    v_f = flags[FLAG_V];
    c_f = flags[FLAG_C];
  end

  // Each even/odd pair shares one base test; the low bit of the code
  // picks the test itself (odd) or its complement (even).
  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    localparam logic [3:0] CI = 4'(i);
    logic base;
    always_comb begin
      unique case ({CI[3], CI[2:1]})
        3'b000:  base = 1'b1;
        3'b001:  base = z_f;
        3'b010:  base = n_f ^ v_f;
        3'b011:  base = z_f | (n_f ^ v_f);
        3'b100:  base = n_f;
        3'b101:  base = c_f | z_f;
        3'b110:  base = v_f;
        default: base = c_f;
      endcase
      cond_tbl[i] = base ^ ~CI[0];
    end
  end

  assign cond_ok = cond_tbl[cond];
endmodule

// File: rtl/brc_target.sv
module brc_target
  import brc_pkg::*;
#(
  parameter int W = 16
) (
  input  dec_t         dec,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] loop_cur,
  input  logic         cond_ok,
  output logic         taken,
  output logic [W-1:0] next_pc,
  output logic         not_branch,
  output logic         loop_we,
  output logic [2:0]   loop_idx,
  output logic [W-1:0] loop_next
);
  localparam int LOOP_OFF_W = 6;

  logic [W-1:0] br_off;
  logic [W-1:0] lp_off;
  logic [W-1:0] dec_val;

  always_comb begin
    br_off  = {{(W-9){dec.disp[7]}}, dec.disp, 1'b0};
    lp_off  = {{(W-LOOP_OFF_W-1){1'b0}}, dec.disp[LOOP_OFF_W-1:0], 1'b0};
    dec_val = loop_cur - W'(1);
  end

  always_comb begin
    taken      = 1'b0;
    next_pc    = pc;
    not_branch = 1'b0;
    loop_we    = 1'b0;
    loop_idx   = dec.ridx;
    loop_next  = dec_val;
    unique case (dec.kind)
      K_BRANCH: begin
        taken = cond_ok;
        if (cond_ok) next_pc = pc + br_off;
      end
      K_LOOP: begin
        loop_we = 1'b1;
        taken   = (dec_val != '0);
        if (dec_val != '0) next_pc = pc - lp_off;
      end
      default: not_branch = 1'b1;
    endcase
  end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [15:0]  in_instr,
  input  logic [3:0]   in_flags,
  input  logic [W-1:0] in_pc,
  input  logic [W-1:0] in_loop_val,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_taken,
  output logic [W-1:0] out_next_pc,
  output logic         out_not_branch,
  output logic         out_loop_we,
  output logic [2:0]   out_loop_idx,
  output logic [W-1:0] out_loop_val
);
  localparam logic [W-1:0] FWD_REACH = W'(254);
  localparam logic [W-1:0] BWD_REACH = W'(256);
  localparam logic [W-1:0] LOOP_REACH = W'(126);

  dec_t         dec;
  logic         cond_ok;
  logic         nx_taken;
  logic [W-1:0] nx_pc;
  logic         nx_nb;
  logic         nx_we;
  logic [2:0]   nx_idx;
  logic [W-1:0] nx_val;
  logic         accept;

  brc_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  brc_cond_eval u_cond (
    .flags   (in_flags),
    .cond    (dec.cond),
    .cond_ok (cond_ok)
  );

  brc_target #(.W(W)) u_tgt (
    .dec        (dec),
    .pc         (in_pc),
    .loop_cur   (in_loop_val),
    .cond_ok    (cond_ok),
    .taken      (nx_taken),
    .next_pc    (nx_pc),
    .not_branch (nx_nb),
    .loop_we    (nx_we),
    .loop_idx   (nx_idx),
    .loop_next  (nx_val)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_taken      <= 1'b0;
      out_next_pc    <= '0;
      out_not_branch <= 1'b0;
      out_loop_we    <= 1'b0;
      out_loop_idx   <= '0;
      out_loop_val   <= '0;
    end else begin
      if (accept) begin
        out_valid      <= 1'b1;
        out_taken      <= nx_taken;
        out_next_pc    <= nx_pc;
        out_not_branch <= nx_nb;
        out_loop_we    <= nx_we;
        out_loop_idx   <= nx_idx;
        out_loop_val   <= nx_val;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_NB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_not_branch |-> !out_taken && !out_loop_we); // R1

  AST_BR_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    accept && nx_taken && dec.kind == K_BRANCH |=>
      (W'(out_next_pc - $past(in_pc)) <= FWD_REACH ||
       W'($past(in_pc) - out_next_pc) <= BWD_REACH) &&
      !out_next_pc[0] == !$past(in_pc[0])); // R2

  AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !nx_taken |=> out_next_pc == $past(in_pc)); // R5

  AST_LOOP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_loop_we |-> out_taken == (out_loop_val != '0)); // R6

  AST_LOOP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && nx_we && nx_taken |=>
      W'($past(in_pc) - out_next_pc) <= LOOP_REACH); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) &&
      $stable(out_taken) && $stable(out_loop_val) && $stable(out_loop_we)); // R7

  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R7
endmodule

// File: tb/brc_unit_bench.sv
`timescale 1ns/1ps
module brc_unit_bench;
  typedef struct packed {
    logic        taken;
    logic [15:0] next_pc;
    logic        nb;
    logic        we;
    logic [2:0]  idx;
    logic [15:0] val;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_instr = '0;
  logic [3:0]  in_flags = '0;
  logic [15:0] in_pc = '0;
  logic [15:0] in_loop_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_taken;
  logic [15:0] out_next_pc;
  logic        out_not_branch;
  logic        out_loop_we;
  logic [2:0]  out_loop_idx;
  logic [15:0] out_loop_val;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    stim_done = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  brc_unit u_brc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_flags(in_flags), .in_pc(in_pc),
    .in_loop_val(in_loop_val), .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_next_pc(out_next_pc),
    .out_not_branch(out_not_branch), .out_loop_we(out_loop_we),
    .out_loop_idx(out_loop_idx), .out_loop_val(out_loop_val)
  );

  function automatic void model(input logic [15:0] ins, input logic [3:0] fl,
                                input logic [15:0] pc, input logic [15:0] lv,
                                output exp_t e, output string tag);
    logic n, z, v, c, hit, t;
    logic [15:0] op;
    {n, z, v, c} = fl;
    e = '0;
    e.next_pc = pc;
    hit = 1'b1;
    t = 1'b0;
    op = ins & 16'o177400;
    if ((ins & 16'o177000) == 16'o077000) begin
      e.we = 1'b1; e.idx = ins[8:6]; e.val = lv - 16'd1;
      e.taken = (e.val != 16'd0);
      if (e.taken) e.next_pc = pc - {9'd0, ins[5:0], 1'b0};
      tag = "R6";
    end else begin
      case (op)
        16'o000400: t = 1'b1;
        16'o001000: t = !z;
        16'o001400: t = z;
        16'o002000: t = !(n ^ v);
        16'o002400: t = n ^ v;
        16'o003000: t = !(z | (n ^ v));
        16'o003400: t = z | (n ^ v);
        16'o100000: t = !n;
        16'o100400: t = n;
        16'o101000: t = !(c | z);
        16'o101400: t = c | z;
        16'o102000: t = !v;
        16'o102400: t = v;
        16'o103000: t = !c;
        16'o103400: t = c;
        default:    hit = 1'b0;
      endcase
      if (!hit) begin
        e.nb = 1'b1; tag = "R1";
      end else begin
        e.taken = t;
        if (t) e.next_pc = pc + {{7{ins[7]}}, ins[7:0], 1'b0};
        if (!t) tag = "R5";
        else if (ins[15]) tag = "R2 R4";
        else tag = "R2 R3";
      end
    end
  endfunction

  task automatic send(input logic [15:0] ins, input logic [3:0] fl,
                      input logic [15:0] pc, input logic [15:0] lv);
    exp_t e;
    string tag;
    model(ins, fl, pc, lv, e, tag);
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_flags = fl; in_pc = pc; in_loop_val = lv;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  // output back-pressure pattern
  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
    end
  end

  // scoreboard monitor
  initial begin
    exp_t  e;
    string tg;
    bit    stalled = 0;
    logic [15:0] h_pc = '0;
    logic        h_tk = 1'b0;
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n) begin
        if (stalled) begin
          n_checks++;
          if (!out_valid || out_next_pc !== h_pc || out_taken !== h_tk) begin
            n_fail++;
            $display("FAIL R7 stall hold: valid=%0b pc=%h tk=%0b expected pc=%h tk=%0b",
                     out_valid, out_next_pc, out_taken, h_pc, h_tk);
          end
        end
        stalled = out_valid && !out_ready;
        h_pc = out_next_pc;
        h_tk = out_taken;
        if (out_valid && out_ready) begin
          n_checks++;
          if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7 unexpected result: pc=%h expected none", out_next_pc);
          end else begin
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            if (out_taken !== e.taken || out_next_pc !== e.next_pc ||
                out_not_branch !== e.nb || out_loop_we !== e.we ||
                (e.we && (out_loop_idx !== e.idx || out_loop_val !== e.val))) begin
              n_fail++;
              $display("FAIL %s: tk=%0b pc=%h nb=%0b we=%0b idx=%0d val=%h expected tk=%0b pc=%h nb=%0b we=%0b idx=%0d val=%h",
                       tg, out_taken, out_next_pc, out_not_branch, out_loop_we,
                       out_loop_idx, out_loop_val, e.taken, e.next_pc, e.nb,
                       e.we, e.idx, e.val);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!stim_done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] base_ops [15];
    base_ops = '{16'o000400, 16'o001000, 16'o001400, 16'o002000, 16'o002400,
                 16'o003000, 16'o003400, 16'o100000, 16'o100400, 16'o101000,
                 16'o101400, 16'o102000, 16'o102400, 16'o103000, 16'o103400};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8 reset state
    n_checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R8 reset: valid=%0b ready=%0b expected valid=0 ready=1",
               out_valid, in_ready);
    end
    // R3 R4 R5: every condition under every flag pattern
    for (int k = 0; k < 15; k++)
      for (int f = 0; f < 16; f++)
        send(base_ops[k] | 16'(f * 5 + k), 4'(f), 16'h4000 + 16'(f * 2), 16'h0);
    // R2 displacement extremes and wrap
    send(16'o000400 | 16'o000177, 4'h0, 16'h1000, 16'h0);
    send(16'o000400 | 16'o000200, 4'h0, 16'h1000, 16'h0);
    send(16'o000400 | 16'o000377, 4'h0, 16'h0000, 16'h0);
    send(16'o000400 | 16'o000001, 4'h0, 16'hFFFE, 16'h0);
    // R6 loop: taken, terminating, wrap from zero, extreme distances
    send(16'o077000 | 16'o000077, 4'h0, 16'h2000, 16'd5);
    send(16'o077000 | 16'o000300, 4'h0, 16'h2000, 16'd1);
    send(16'o077000 | 16'o000501, 4'h0, 16'h0010, 16'd0);
    send(16'o077777,              4'h0, 16'h3000, 16'd2);
    send(16'o077100,              4'hF, 16'h3000, 16'd9);
    // R1 words outside both encodings
    send(16'o000000, 4'hF, 16'h0100, 16'h0);
    send(16'o000377, 4'hF, 16'h0100, 16'h0);
    send(16'o004400, 4'hF, 16'h0100, 16'h0);
    send(16'o104000, 4'hF, 16'h0100, 16'h0);
    send(16'o076777, 4'hF, 16'h0100, 16'd3);
    send(16'o177777, 4'hF, 16'h0100, 16'd3);
    // mixed random words
    for (int r = 0; r < 300; r++)
      send(16'($urandom), 4'($urandom), 16'($urandom), 16'($urandom_range(0, 3)));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2000) begin
      @(negedge clk);
      if (exp_q.size() == 0) break;
    end
    repeat (4) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R7 results missing: %0d left expected 0", exp_q.size());
    end
    stim_done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule